// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block turns a fast source clock into two outputs for a display pipeline. The first is a pixel tick: a strobe that lasts one source cycle and marks the start of each pixel period. The second is a pixel clock waveform whose rising and falling edges sit at programmable points inside that period. The divide ratio is an unsigned fixed-point number with an 8-bit integer part and a 4-bit fraction. A phase accumulator spreads the fraction across successive periods. Each period is therefore either the integer part or the integer part plus one source cycles long, and the long-run average equals the programmed ratio exactly.

Software works out the ratio as the rounded quotient of the source rate over the wanted pixel rate. Any value below one is treated as one. To get a 50% duty cycle, place the rising edge at zero and the falling edge at the integer divider value, since edge positions are counted in half-cycle steps. The block samples its three configuration inputs only at period boundaries. A value changed part-way through a period therefore never shortens or stretches the waveform already in progress.

Top module: `pclk_frac_div`

## Requirements
- R1: While `rst_n` is low, `pix_tick` and `pix_clk` are both 0.
- R2: `div_cfg` is an unsigned 8.4 fixed-point ratio (bits 11:4 integer, bits 3:0 sixteenths). Each period lasts floor(div_cfg/16) or floor(div_cfg/16)+1 source cycles. Any 16 consecutive periods together last exactly `div_cfg` cycles when counted in sixteenths, which is 16*integer + fraction cycles.
- R3: A `div_cfg` below 0x10 behaves exactly like 0x10, so every period is one source cycle long.
- R4: `pix_tick` is 1 for exactly the first source cycle of every period. With one-cycle periods it stays high continuously.
- R5: `rise_pos` and `fall_pos` are 9-bit positions counted in half source cycles. A position p acts at cycle index ceil(p/2) of the period, where index 0 is the tick cycle. At the rise index the waveform goes to 1 and at the fall index it goes to 0; if both land on the same index, the fall wins. At every other index, including across period boundaries, the level holds. A rise index later than the fall index therefore gives an inverted pulse.
- R6: With `rise_pos`=0 and `fall_pos` equal to an even integer divider N, the waveform is high for the first N/2 cycles of each N-cycle period.
- R7: An edge whose index is at or beyond the current period length has no effect in that period.
- R8: Changes to `div_cfg`, `rise_pos` or `fall_pos` made during a period take effect only from the next period. The period in progress completes with its old length and edges.
- R9: At the largest setting, 0xFFF, periods are 255 or 256 cycles long, and 16 consecutive periods total 4095 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | 12 | Divide ratio, 8.4 fixed point |
| rise_pos | input | 9 | Rising-edge position in half cycles |
| fall_pos | input | 9 | Falling-edge position in half cycles |
| pix_clk | output | 1 | Generated pixel clock waveform |
| pix_tick | output | 1 | One-cycle strobe at each period start |

## Verification
The bound checker watches several properties on every cycle:
- a tick appears exactly one cycle after each internal period start and at no other time;
- the position counter stays below the current length;
- each newly loaded length is the integer part of the sampled ratio or one more;
- the length never changes except at a boundary;
- the gap between ticks never exceeds the largest legal period.

Some behaviours only the bench scenarios can show: the exact sum over 16 periods for a given fraction, the duty and level pattern that each edge placement produces (half-step rounding, fall priority, inverted pulses, edges beyond the period), and the deferred application of a mid-period change.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_RISE = 2'd1,
      ACT_FALL = 2'd2
   } edge_act_e;

endpackage

// File: rtl/pclk_phase_acc.sv
module pclk_phase_acc #(
   parameter int FRAC_W = 4
) (
   input  logic              clk_src,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [FRAC_W-1:0] frac_in,
   output logic              carry
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;

   // carry out of the residue decides whether the coming period is long
   assign sum   = {1'b0, acc_q} + {1'b0, frac_in};
   assign carry = sum[FRAC_W];

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (adv) begin
         acc_q <= sum[FRAC_W-1:0];
      end
   end
endmodule

// File: rtl/pclk_period_ctr.sv
module pclk_period_ctr #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 4,
   parameter int EDGE_W = 9
) (
   input  logic                    clk_src,
   input  logic                    rst_n,
   input  logic [INT_W+FRAC_W-1:0] div_cfg,
   input  logic [EDGE_W-1:0]       rise_pos,
   input  logic [EDGE_W-1:0]       fall_pos,
   output logic [INT_W:0]          cnt,
   output logic [INT_W:0]          len,
   output logic [EDGE_W-1:0]       rise_idx,
   output logic [EDGE_W-1:0]       fall_idx,
   output logic                    wrap
);
   localparam int DIV_W = INT_W + FRAC_W;
   localparam int LEN_W = INT_W + 1;

   logic [LEN_W-1:0]  cnt_q, len_q;
   logic [EDGE_W-1:0] rise_q, fall_q;
   logic [INT_W-1:0]  int_raw;
   logic [FRAC_W-1:0] frac_eff;
   logic [LEN_W-1:0]  int_eff;
   logic              carry;
   logic [EDGE_W:0]   rise_ext, fall_ext;

   // ratios below one are forced to exactly one
   assign int_raw  = div_cfg[DIV_W-1:FRAC_W];
   assign int_eff  = (int_raw == '0) ? LEN_W'(1) : {1'b0, int_raw};
   assign frac_eff = (int_raw == '0) ? '0 : div_cfg[FRAC_W-1:0];

   // half-step position rounds up to the next whole source cycle
   assign rise_ext = {1'b0, rise_pos} + 1'b1;
   assign fall_ext = {1'b0, fall_pos} + 1'b1;

   assign wrap = (cnt_q == len_q - 1'b1);

   pclk_phase_acc #(.FRAC_W(FRAC_W)) acc_i (
      .clk_src (clk_src),
      .rst_n   (rst_n),
      .adv     (wrap),
      .frac_in (frac_eff),
      .carry   (carry)
   );

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         len_q  <= LEN_W'(1);
         rise_q <= '0;
         fall_q <= '0;
      end else if (wrap) begin
         cnt_q  <= '0;
         len_q  <= int_eff + LEN_W'(carry);
         rise_q <= rise_ext[EDGE_W:1];
         fall_q <= fall_ext[EDGE_W:1];
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign cnt      = cnt_q;
   assign len      = len_q;
   assign rise_idx = rise_q;
   assign fall_idx = fall_q;
endmodule

// File: rtl/pclk_edge_gen.sv
module pclk_edge_gen
   import pclk_div_pkg::*;
#(
   parameter int LEN_W     = 9,
   parameter int EDGE_W    = 9,
   parameter bit FALL_WINS = 1'b1
) (
   input  logic              clk_src,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  cnt,
   input  logic [EDGE_W-1:0] rise_idx,
   input  logic [EDGE_W-1:0] fall_idx,
   output logic              pix_clk,
   output logic              pix_tick
);
   localparam int CMP_W = (LEN_W > EDGE_W) ? LEN_W : EDGE_W;

   logic [CMP_W-1:0] cnt_x, rise_x, fall_x;
   edge_act_e        act;
   logic             lvl_q, tick_q;

   assign cnt_x  = CMP_W'(cnt);
   assign rise_x = CMP_W'(rise_idx);
   assign fall_x = CMP_W'(fall_idx);

   generate
      if (FALL_WINS) begin : g_fall_first
         always_comb begin
            if (cnt_x == fall_x)      act = ACT_FALL;
            else if (cnt_x == rise_x) act = ACT_RISE;
            else                      act = ACT_HOLD;
         end
      end else begin : g_rise_first
         always_comb begin
            if (cnt_x == rise_x)      act = ACT_RISE;
            else if (cnt_x == fall_x) act = ACT_FALL;
            else                      act = ACT_HOLD;
         end
      end
   endgenerate

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= (cnt == '0);
         case (act)
            ACT_RISE: lvl_q <= 1'b1;
            ACT_FALL: lvl_q <= 1'b0;
            default:  lvl_q <= lvl_q;
         endcase
      end
   end

   assign pix_clk  = lvl_q;
   assign pix_tick = tick_q;
endmodule

// File: rtl/pclk_frac_div.sv
module pclk_frac_div #(
   parameter int INT_W     = 8,
   parameter int FRAC_W    = 4,
   parameter int EDGE_W    = 9,
   parameter bit FALL_WINS = 1'b1
) (
   input  logic                    clk_src,
   input  logic                    rst_n,
   input  logic [INT_W+FRAC_W-1:0] div_cfg,
   input  logic [EDGE_W-1:0]       rise_pos,
   input  logic [EDGE_W-1:0]       fall_pos,
   output logic                    pix_clk,
   output logic                    pix_tick
);
   localparam int LEN_W = INT_W + 1;

   generate
      if (INT_W < 1 || INT_W > 16) begin : g_bad_int
         $error("pclk_frac_div: INT_W out of range");
      end
      if (FRAC_W < 1 || FRAC_W > 16) begin : g_bad_frac
         $error("pclk_frac_div: FRAC_W out of range");
      end
      if (EDGE_W < 2) begin : g_bad_edge
         $error("pclk_frac_div: EDGE_W too small");
      end
   endgenerate

   logic [LEN_W-1:0]  cnt_w, len_w;
   logic [EDGE_W-1:0] rise_w, fall_w;
   logic              wrap_w;

   pclk_period_ctr #(.INT_W(INT_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W)) ctr_i (
      .clk_src  (clk_src),
      .rst_n    (rst_n),
      .div_cfg  (div_cfg),
      .rise_pos (rise_pos),
      .fall_pos (fall_pos),
      .cnt      (cnt_w),
      .len      (len_w),
      .rise_idx (rise_w),
      .fall_idx (fall_w),
      .wrap     (wrap_w)
   );

   pclk_edge_gen #(.LEN_W(LEN_W), .EDGE_W(EDGE_W), .FALL_WINS(FALL_WINS)) edge_i (
      .clk_src  (clk_src),
      .rst_n    (rst_n),
      .cnt      (cnt_w),
      .rise_idx (rise_w),
      .fall_idx (fall_w),
      .pix_clk  (pix_clk),
      .pix_tick (pix_tick)
   );
endmodule

// File: rtl/pclk_frac_div_chk.sv
module pclk_frac_div_chk #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 4
) (
   input logic                    clk_src,
   input logic                    rst_n,
   input logic [INT_W+FRAC_W-1:0] div_cfg,
   input logic                    pix_tick,
   input logic [INT_W:0]          cnt,
   input logic [INT_W:0]          len,
   input logic                    wrap
);
   localparam int LEN_W   = INT_W + 1;
   localparam int GAP_W   = INT_W + 2;
   localparam int MAX_LEN = 1 << INT_W;

   logic [LEN_W-1:0] whole;
   logic [GAP_W-1:0] gap_q;

   assign whole = (div_cfg[INT_W+FRAC_W-1:FRAC_W] == '0) ? LEN_W'(1)
                : {1'b0, div_cfg[INT_W+FRAC_W-1:FRAC_W]};

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n)                  gap_q <= '0;
      else if (pix_tick)           gap_q <= GAP_W'(1);
      else if (gap_q != '1)        gap_q <= gap_q + 1'b1;
   end

   AST_TICK_AFTER_START: assert property (@(posedge clk_src) disable iff (!rst_n)
      (cnt == '0) |=> pix_tick);                                          // R4
   AST_TICK_ONLY_AT_START: assert property (@(posedge clk_src) disable iff (!rst_n)
      (cnt != '0) |=> !pix_tick);                                         // R4
   AST_CNT_BELOW_LEN: assert property (@(posedge clk_src) disable iff (!rst_n)
      cnt < len);                                                         // R2
   AST_LEN_FLOOR_OR_CEIL: assert property (@(posedge clk_src) disable iff (!rst_n)
      wrap |=> (len == $past(whole) || len == $past(whole) + 1'b1));      // R2
   AST_LEN_NONZERO: assert property (@(posedge clk_src) disable iff (!rst_n)
      len != '0);                                                         // R3
   AST_LEN_HELD_MIDPERIOD: assert property (@(posedge clk_src) disable iff (!rst_n)
      !wrap |=> $stable(len));                                            // R8
   AST_GAP_BOUND: assert property (@(posedge clk_src) disable iff (!rst_n)
      pix_tick |-> (gap_q <= GAP_W'(MAX_LEN)));                           // R9
endmodule

bind pclk_frac_div pclk_frac_div_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
   .clk_src  (clk_src),
   .rst_n    (rst_n),
   .div_cfg  (div_cfg),
   .pix_tick (pix_tick),
   .cnt      (cnt_w),
   .len      (len_w),
   .wrap     (wrap_w)
);

// File: tb/pclk_frac_div_tb.sv
module pclk_frac_div_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] div_cfg = 12'h010;
   logic [8:0]  rise_pos = '0;
   logic [8:0]  fall_pos = 9'd1;
   logic        pix_clk, pix_tick;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   pclk_frac_div dut_i (
      .clk_src (clk),
      .rst_n   (rst_n),
      .div_cfg (div_cfg),
      .rise_pos(rise_pos),
      .fall_pos(fall_pos),
      .pix_clk (pix_clk),
      .pix_tick(pix_tick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic next_tick();
      @(negedge clk);
      while (!pix_tick) @(negedge clk);
   endtask

   // starts on a tick sample, ends on the next tick sample
   task automatic get_period(output int cyc, output int highs, output int first_lvl);
      cyc = 0; highs = 0; first_lvl = int'(pix_clk);
      do begin
         cyc++; highs += int'(pix_clk);
         @(negedge clk);
      end while (!pix_tick);
   endtask

   task automatic apply(input logic [11:0] d, input logic [8:0] r, input logic [8:0] f);
      div_cfg = d; rise_pos = r; fall_pos = f;
      repeat (3) next_tick();
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(pix_tick == 1'b0, "R1 tick in reset", int'(pix_tick), 0);
      check(pix_clk == 1'b0, "R1 clk in reset", int'(pix_clk), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_div_one(input logic [11:0] d, input string req);
      int c, h, l;
      apply(d, 9'd0, 9'd1);
      for (int i = 0; i < 8; i++) begin
         get_period(c, h, l);
         check(c == 1, req, c, 1);
      end
      check(pix_tick == 1'b1, "R4 tick held at ratio one", int'(pix_tick), 1);
   endtask

   task automatic t_sum16(input logic [11:0] d, input string req);
      int c, h, l, sum, ok, whole;
      whole = int'(d[11:4]);
      apply(d, 9'd0, 9'd2);
      sum = 0; ok = 1;
      for (int i = 0; i < 16; i++) begin
         get_period(c, h, l);
         sum += c;
         if (c != whole && c != whole + 1) ok = 0;
      end
      check(ok == 1, {req, " period length set"}, c, whole);
      check(sum == int'(d), {req, " sum of 16 periods"}, sum, int'(d));
   endtask

   task automatic t_shape(input logic [11:0] d, input logic [8:0] r, input logic [8:0] f,
                          input int exp_len, input int exp_hi, input int exp_first,
                          input string req);
      int c, h, l;
      apply(d, r, f);
      get_period(c, h, l);
      check(c == exp_len, {req, " length"}, c, exp_len);
      check(h == exp_hi, {req, " high cycles"}, h, exp_hi);
      check(l == exp_first, {req, " level at tick"}, l, exp_first);
   endtask

   task automatic t_midchange();
      int c, h, l;
      apply(12'h080, 9'd0, 9'd8);
      c = 0; h = 0;
      repeat (2) begin c++; h += int'(pix_clk); @(negedge clk); end
      div_cfg = 12'h020; fall_pos = 9'd2;
      do begin c++; h += int'(pix_clk); @(negedge clk); end while (!pix_tick);
      check(c == 8, "R8 old length kept", c, 8);
      check(h == 4, "R8 old edges kept", h, 4);
      get_period(c, h, l);
      check(c == 2, "R8 new length next period", c, 2);
      check(h == 1, "R8 new edges next period", h, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R4 watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_div_one(12'h010, "R2 ratio one");
      t_div_one(12'h005, "R3 ratio below one");
      t_sum16(12'h048, "R2 ratio 4.5");
      t_sum16(12'h04B, "R2 ratio 4.6875");
      t_shape(12'h080, 9'd0, 9'd8, 8, 4, 1, "R6 half duty");
      t_shape(12'h060, 9'd1, 9'd5, 6, 2, 0, "R5 half-step edges");
      t_shape(12'h060, 9'd6, 9'd2, 6, 4, 1, "R5 inverted pulse");
      t_shape(12'h060, 9'd4, 9'd4, 6, 0, 0, "R5 fall wins tie");
      t_shape(12'h040, 9'd0, 9'd20, 4, 4, 1, "R7 fall beyond period");
      t_midchange();
      t_sum16(12'hFFF, "R9 largest ratio");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule